// File: doc/BRIEF.md
# DRAM Strobe Sequencer and Address Multiplexer

This block converts a processor memory access into the strobe sequence needed by a dynamic RAM whose fourteen address bits arrive as two seven-bit halves on one shared bus. An internal request, raised while either the active-low read strobe or the active-low write strobe is low, releases a small clocked sequencer from clear. The sequencer then advances by one rising clock edge per step: it arms, it switches the address multiplexer, and finally it drops the column strobe. The row strobe is not clocked. It falls as soon as a request aimed at the RAM region begins.

The sequencer has four named states. `SQ_WAIT` is the cleared state: the request is absent, or it has begun and no edge has arrived yet. `SQ_PRIMED` follows the first edge. `SQ_SWITCHED` follows the second edge and asserts the mux select. `SQ_STROBED` follows the third edge and drives the column strobe. The clock transitions are named: arm (WAIT to PRIMED), switch (PRIMED to SWITCHED), strobe (SWITCHED to STROBED) and hold (STROBED to STROBED). A further transition, release, is asynchronous. Whenever the request drops, every state returns to `SQ_WAIT` at once, without waiting for a clock.

Top module: `dram_strobe_seq`

## Requirements
- R1: With both `rd_n` and `wr_n` high, the outputs are idle: `ras_n`=1, `mux_sel`=0, `cas_n`=1, and `dram_addr` carries `cpu_addr[6:0]`.
- R2: When a read or write begins with `ram_sel`=1, `ras_n` goes low in the same cycle, before any clock edge, while `mux_sel` stays 0 and `cas_n` stays 1.
- R3: `mux_sel` stays 0 after the first rising edge of a request and becomes 1 after the second rising edge.
- R4: `cas_n` goes low after the third rising edge of a request, one edge after `mux_sel` rose.
- R5: While the strobe stays low, `ras_n`=0, `mux_sel`=1 and `cas_n`=0 are held for any number of further edges.
- R6: When the strobe returns high, every output returns to the idle values of R1 within that cycle, whichever step the sequence had reached.
- R7: `dram_addr` is `cpu_addr[6:0]` (row half) while `mux_sel`=0 and `cpu_addr[13:7]` (column half) while `mux_sel`=1.
- R8: A read (`rd_n` low) and a write (`wr_n` low) produce the identical strobe sequence.
- R9: With `ram_sel`=0, an access leaves `ras_n` and `cas_n` high throughout.
- R10: A request that follows a released one restarts the sequence from `SQ_WAIT`, counting its edges afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; the sequencer advances on rising edges |
| rd_n | input | 1 | Active-low memory read strobe |
| wr_n | input | 1 | Active-low memory write strobe |
| ram_sel | input | 1 | High when the access address lies in the RAM region |
| cpu_addr | input | 14 | Processor address for the RAM |
| ras_n | output | 1 | Active-low row address strobe |
| mux_sel | output | 1 | High while the column half is on `dram_addr` |
| cas_n | output | 1 | Active-low column address strobe |
| dram_addr | output | 7 | Multiplexed row/column address bus |

## Verification
The assertions assume three things about the inputs. `rd_n` and `wr_n` change only away from the rising clock edge. `ram_sel` is stable for the whole of a request. A released request stays released across at least one rising edge before the next request begins. The bench drives every input on the falling edge, holds `ram_sel` constant within each access, and leaves at least one full idle clock between accesses. Under those conditions the properties check the order of mux and column strobe and their persistence while the request lasts, and are disabled whenever the request is absent.

// File: rtl/dss_pkg.sv
package dss_pkg;

    typedef enum logic [1:0] {
        SQ_WAIT     = 2'd0,
        SQ_PRIMED   = 2'd1,
        SQ_SWITCHED = 2'd2,
        SQ_STROBED  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/dss_req_decode.sv
module dss_req_decode (
    input  logic rd_n,
    input  logic wr_n,
    input  logic ram_sel,
    output logic mem_req,
    output logic row_strobe
);

    // Request is high whenever either active-low strobe is asserted.
    always_comb begin
        mem_req    = ~(rd_n & wr_n);
        row_strobe = mem_req & ram_sel;
    end

endmodule

// File: rtl/dss_seq_fsm.sv
module dss_seq_fsm
    import dss_pkg::*;
(
    input  logic clk,
    input  logic mem_req,
    output logic mux_phase,
    output logic col_phase
);

    seq_state_t state_q;
    seq_state_t state_d;

    // Next-state: one step per rising edge, then hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_WAIT:     state_d = SQ_PRIMED;
            SQ_PRIMED:   state_d = SQ_SWITCHED;
            SQ_SWITCHED: state_d = SQ_STROBED;
            SQ_STROBED:  state_d = SQ_STROBED;
        endcase
    end

    // State register, held in clear while no request is present.
    always_ff @(posedge clk or negedge mem_req) begin
        if (!mem_req) begin
            state_q <= SQ_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        mux_phase = 1'b0;
        col_phase = 1'b0;
        unique case (state_q)
            SQ_WAIT:     ;
            SQ_PRIMED:   ;
            SQ_SWITCHED: mux_phase = 1'b1;
            SQ_STROBED: begin
                mux_phase = 1'b1;
                col_phase = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dss_addr_mux.sv
module dss_addr_mux #(
    parameter int ROW_W = 7
) (
    input  logic [2*ROW_W-1:0] addr_in,
    input  logic               pick_col,
    output logic [ROW_W-1:0]   addr_out
);

    localparam int ADDR_W = 2 * ROW_W;

    logic [ROW_W-1:0] row_half;
    logic [ROW_W-1:0] col_half;

    always_comb begin
        row_half = addr_in[ROW_W-1:0];
        col_half = addr_in[ADDR_W-1:ROW_W];
        addr_out = pick_col ? col_half : row_half;
    end

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq #(
    parameter int ROW_W = 7
) (
    input  logic               clk,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic               ram_sel,
    input  logic [2*ROW_W-1:0] cpu_addr,
    output logic               ras_n,
    output logic               mux_sel,
    output logic               cas_n,
    output logic [ROW_W-1:0]   dram_addr
);

    logic mem_req;
    logic row_strobe;
    logic mux_phase;
    logic col_phase;

    dss_req_decode u_req (
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .ram_sel    (ram_sel),
        .mem_req    (mem_req),
        .row_strobe (row_strobe)
    );

    dss_seq_fsm u_fsm (
        .clk       (clk),
        .mem_req   (mem_req),
        .mux_phase (mux_phase),
        .col_phase (col_phase)
    );

    dss_addr_mux #(.ROW_W(ROW_W)) u_mux (
        .addr_in  (cpu_addr),
        .pick_col (mux_phase),
        .addr_out (dram_addr)
    );

    always_comb begin
        ras_n   = ~row_strobe;
        mux_sel = mux_phase;
        cas_n   = ~(col_phase & ram_sel);
    end

endmodule

// File: rtl/dss_chk.sv
module dss_chk #(
    parameter int ROW_W = 7
) (
    input logic               clk,
    input logic               rd_n,
    input logic               wr_n,
    input logic               ram_sel,
    input logic [2*ROW_W-1:0] cpu_addr,
    input logic               ras_n,
    input logic               mux_sel,
    input logic               cas_n,
    input logic [ROW_W-1:0]   dram_addr
);

    logic req_seen;
    assign req_seen = ~(rd_n & wr_n);

    // R2
    ras_low_in_ram_chk: assert property (@(posedge clk) disable iff (!req_seen)
        ram_sel |-> !ras_n);

    // R4
    cas_after_mux_chk: assert property (@(posedge clk) disable iff (!req_seen)
        !cas_n |-> mux_sel);

    // R4
    cas_fall_order_chk: assert property (@(posedge clk) disable iff (!req_seen)
        $fell(cas_n) |-> $past(mux_sel));

    // R5
    mux_hold_chk: assert property (@(posedge clk) disable iff (!req_seen)
        mux_sel |=> mux_sel);

    // R5
    cas_hold_chk: assert property (@(posedge clk) disable iff (!req_seen)
        !cas_n |=> !cas_n);

    // R7
    col_half_chk: assert property (@(posedge clk) disable iff (!req_seen)
        mux_sel |-> dram_addr == cpu_addr[2*ROW_W-1:ROW_W]);

    // R9
    non_ram_quiet_chk: assert property (@(posedge clk) disable iff (!req_seen)
        !ram_sel |-> (ras_n && cas_n));

endmodule

bind dram_strobe_seq dss_chk #(.ROW_W(ROW_W)) u_dss_chk (
    .clk       (clk),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ram_sel   (ram_sel),
    .cpu_addr  (cpu_addr),
    .ras_n     (ras_n),
    .mux_sel   (mux_sel),
    .cas_n     (cas_n),
    .dram_addr (dram_addr)
);

// File: tb/dram_strobe_seq_tb_top.sv
module dram_strobe_seq_tb_top;

    localparam int ROW_W = 7;

    logic               clk;
    logic               rd_n;
    logic               wr_n;
    logic               ram_sel;
    logic [2*ROW_W-1:0] cpu_addr;
    logic               ras_n;
    logic               mux_sel;
    logic               cas_n;
    logic [ROW_W-1:0]   dram_addr;

    int n_checks = 0;
    int n_fail   = 0;

    dram_strobe_seq #(.ROW_W(ROW_W)) dut_i (
        .clk       (clk),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ram_sel   (ram_sel),
        .cpu_addr  (cpu_addr),
        .ras_n     (ras_n),
        .mux_sel   (mux_sel),
        .cas_n     (cas_n),
        .dram_addr (dram_addr)
    );

    initial begin
        clk = 1'b0;
        forever #10 clk = ~clk;
    end

    task automatic expect_out(input string tag, input logic e_ras, input logic e_mux,
                              input logic e_cas, input logic [ROW_W-1:0] e_addr);
        n_checks++;
        if (ras_n !== e_ras || mux_sel !== e_mux || cas_n !== e_cas || dram_addr !== e_addr) begin
            n_fail++;
            $display("FAIL %s: actual ras_n=%b mux=%b cas_n=%b addr=%h expected ras_n=%b mux=%b cas_n=%b addr=%h",
                     tag, ras_n, mux_sel, cas_n, dram_addr, e_ras, e_mux, e_cas, e_addr);
        end
    endtask

    function automatic logic [ROW_W-1:0] lo_half(input logic [2*ROW_W-1:0] a);
        return a[ROW_W-1:0];
    endfunction

    function automatic logic [ROW_W-1:0] hi_half(input logic [2*ROW_W-1:0] a);
        return a[2*ROW_W-1:ROW_W];
    endfunction

    task automatic drive_strobe(input logic is_write, input logic level);
        if (is_write) wr_n = level;
        else          rd_n = level;
    endtask

    // R1: idle outputs
    task automatic t_idle(input logic [2*ROW_W-1:0] a);
        @(negedge clk);
        cpu_addr = a;
        #2 expect_out("R1 idle", 1'b1, 1'b0, 1'b1, lo_half(a));
    endtask

    // R2 R3 R4 R5 R6 R7 R8: full access with hold
    task automatic t_access(input logic is_write, input int hold,
                            input logic [2*ROW_W-1:0] a, input string kind);
        @(negedge clk);
        cpu_addr = a;
        ram_sel  = 1'b1;
        drive_strobe(is_write, 1'b0);
        #2 expect_out({"R2 ", kind}, 1'b0, 1'b0, 1'b1, lo_half(a));
        @(negedge clk);
        #2 expect_out({"R3 first edge ", kind}, 1'b0, 1'b0, 1'b1, lo_half(a));
        @(negedge clk);
        #2 expect_out({"R3 R7 second edge ", kind}, 1'b0, 1'b1, 1'b1, hi_half(a));
        @(negedge clk);
        #2 expect_out({"R4 R8 third edge ", kind}, 1'b0, 1'b1, 1'b0, hi_half(a));
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            #2 expect_out({"R5 hold ", kind}, 1'b0, 1'b1, 1'b0, hi_half(a));
        end
        @(negedge clk);
        drive_strobe(is_write, 1'b1);
        #1 expect_out({"R6 release ", kind}, 1'b1, 1'b0, 1'b1, lo_half(a));
        @(negedge clk);
        #2 expect_out({"R6 stays idle ", kind}, 1'b1, 1'b0, 1'b1, lo_half(a));
    endtask

    // R6: release while mux is up but before column strobe
    task automatic t_early_release(input logic [2*ROW_W-1:0] a);
        @(negedge clk);
        cpu_addr = a;
        ram_sel  = 1'b1;
        rd_n     = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #2 expect_out("R6 pre-release mux up", 1'b0, 1'b1, 1'b1, hi_half(a));
        rd_n = 1'b1;
        #1 expect_out("R6 early release", 1'b1, 1'b0, 1'b1, lo_half(a));
        @(negedge clk);
        #2 expect_out("R6 no resume", 1'b1, 1'b0, 1'b1, lo_half(a));
    endtask

    // R9: access outside the RAM region
    task automatic t_non_ram(input logic [2*ROW_W-1:0] a);
        @(negedge clk);
        cpu_addr = a;
        ram_sel  = 1'b0;
        wr_n     = 1'b0;
        #2 expect_out("R9 start", 1'b1, 1'b0, 1'b1, lo_half(a));
        repeat (3) @(negedge clk);
        #2 expect_out("R9 after three edges", 1'b1, 1'b1, 1'b1, hi_half(a));
        wr_n = 1'b1;
        #1 expect_out("R9 release", 1'b1, 1'b0, 1'b1, lo_half(a));
        @(negedge clk);
        ram_sel = 1'b1;
    endtask

    // R10: second request restarts counting
    task automatic t_restart(input logic [2*ROW_W-1:0] a);
        @(negedge clk);
        cpu_addr = a;
        ram_sel  = 1'b1;
        wr_n     = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        rd_n = 1'b0;
        #2 expect_out("R10 restart row", 1'b0, 1'b0, 1'b1, lo_half(a));
        @(negedge clk);
        #2 expect_out("R10 first edge again", 1'b0, 1'b0, 1'b1, lo_half(a));
        @(negedge clk);
        #2 expect_out("R10 second edge again", 1'b0, 1'b1, 1'b1, hi_half(a));
        @(negedge clk);
        #2 expect_out("R10 third edge again", 1'b0, 1'b1, 1'b0, hi_half(a));
        rd_n = 1'b1;
        #1 expect_out("R10 release", 1'b1, 1'b0, 1'b1, lo_half(a));
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rd_n     = 1'b1;
        wr_n     = 1'b1;
        ram_sel  = 1'b1;
        cpu_addr = '0;
        repeat (2) @(negedge clk);
        t_idle(14'h2A55);
        t_access(1'b1, 3, 14'h1F80, "write");
        t_access(1'b0, 3, 14'h1F80, "read");
        t_access(1'b0, 0, 14'h007F, "read short");
        t_access(1'b1, 12, 14'h3A5C, "write long");
        t_early_release(14'h2B1D);
        t_non_ram(14'h0C3E);
        t_restart(14'h1234);
        t_idle(14'h3FFF);
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule